// File: doc/BRIEF.md
# Parity-Guarded Block Copy Sender

This block walks a source memory from a loaded start address and hands each 16-bit word to a downstream receiver. Every word goes out with an even parity bit. A request line marks each offer, and the sender then watches the receiver's acknowledge and full lines to decide its next step: move to the next word, offer the same word again, or stop. All of its state changes on the falling clock edge. The receiver works on the rising edge, so it gets half a cycle to judge each offer and answer it.

The outgoing word stream follows valid/ready rules. `tx_req` is the valid and `rx_ack` is the acceptance. A word counts as delivered only at a falling edge where `tx_req` and `rx_ack` are both high. If `rx_ack` is low at that edge, the receiver is pushing back: the same word and parity stay on the bus and `tx_req` stays high. After a delivered word, `tx_req` falls for the two cycles of the next synchronous memory fetch, so each new word is a separate request. A copy ends when an all-ones sentinel word has been delivered (the sentinel is included), when the word at the top source address has been delivered, or as soon as the receiver raises full. `done` then stays high until the next start.

Top module: `pcopy_tx`

## Requirements
- R1: A `start` pulse seen at a falling edge while idle loads `src_base` into the pointer; in the following cycle `mem_rd` is high with `mem_addr` equal to that base.
- R2: Every output changes only at a falling clock edge and holds steady through the rising edge that follows.
- R3: Whenever `tx_req` is high, the 16 bits of `tx_data` plus `tx_parity` together hold an even number of ones.
- R4: `tx_req` is low while a word is fetched. A fetch lasts two cycles (read cycle, then capture cycle), and `tx_req` rises in the cycle after the capture.
- R5: If `rx_ack` is low at a falling edge while `tx_req` is high and full is low, the next cycle presents the same `tx_data` and `tx_parity` with `tx_req` still high.
- R6: A delivered word that is not the sentinel and does not sit at the top address is followed by a fetch at `mem_addr` plus one.
- R7: Delivery of the sentinel word 16'hFFFF ends the copy. At the next edge `tx_req` drops and `done` rises.
- R8: Delivery of the word at the top source address (all address bits one) ends the copy, even when that word is not the sentinel.
- R9: `rx_full` high at a falling edge while a copy is in progress ends the copy at that edge. `done` rises, and `tx_req` and `mem_rd` drop.
- R10: `done` stays high until the next accepted `start`, which clears it at the edge where it is taken.
- R11: `start` while a copy is in progress has no effect on the address sequence or the data sent.
- R12: After reset, `tx_req`, `mem_rd` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the block acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a copy when idle |
| src_base | input | ADDR_W | First source address of a copy |
| mem_rd | output | 1 | Read strobe to the source memory |
| mem_addr | output | ADDR_W | Source memory read address |
| mem_rdata | input | DATA_W | Word returned by the memory, valid the cycle after `mem_rd` |
| tx_data | output | DATA_W | Word offered to the receiver |
| tx_parity | output | 1 | Even parity over `tx_data` |
| tx_req | output | 1 | Offer valid |
| rx_ack | input | 1 | Receiver accepted the offered word |
| rx_full | input | 1 | Receiver storage is full; halt |
| done | output | 1 | Copy finished; sticky until next start |

## Verification
The bench builds the block with ADDR_W set to 6, which gives a 64-word source space. A copy can then run into the top address within a handful of words, so the top-address stop is tested next to the sentinel stop and the full stop. DATA_W keeps its default of 16, so the sentinel is the real all-ones word. The bench's receiver refuses every third offer in one run, which drives repeated resends. It also raises full after a set count in another run, and pulses start in the middle of a copy to show that the pulse is ignored.

// File: rtl/pcopy_pkg.sv
package pcopy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_OFFER = 2'd3
  } cp_state_e;
endpackage

// File: rtl/pcopy_parity.sv
module pcopy_parity #(
  parameter int W = 16
) (
  input  logic [W-1:0] data,
  output logic         even_bit
);
  logic [W-1:0] chain;
  assign chain[0] = data[0];
  for (genvar i = 1; i < W; i++) begin : g_fold
    assign chain[i] = chain[i-1] ^ data[i];
  end
  assign even_bit = chain[W-1];
endmodule

// File: rtl/pcopy_ptr.sv
module pcopy_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addr,
  output logic              at_top
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base;
    else if (step) addr <= addr + 1'b1;
  end

  assign at_top = (addr == TOP);
endmodule

// File: rtl/pcopy_fsm.sv
module pcopy_fsm
  import pcopy_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      rx_ack,
  input  logic      rx_full,
  input  logic      word_is_end,
  input  logic      at_top,
  output cp_state_e state,
  output logic      ptr_load,
  output logic      ptr_step,
  output logic      word_load,
  output logic      done
);
  cp_state_e nxt;
  logic      set_done, clr_done;

  always_comb begin
    nxt       = state;
    ptr_load  = 1'b0;
    ptr_step  = 1'b0;
    word_load = 1'b0;
    set_done  = 1'b0;
    clr_done  = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        nxt      = ST_FETCH;
        ptr_load = 1'b1;
        clr_done = 1'b1;
      end
      ST_FETCH: nxt = ST_WAIT;
      ST_WAIT: begin
        nxt       = ST_OFFER;
        word_load = 1'b1;
      end
      ST_OFFER: if (rx_ack) begin
        if (word_is_end || at_top) begin
          nxt      = ST_IDLE;
          set_done = 1'b1;
        end else begin
          nxt      = ST_FETCH;
          ptr_step = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (state != ST_IDLE && rx_full) begin
      nxt       = ST_IDLE;
      set_done  = 1'b1;
      ptr_step  = 1'b0;
      word_load = 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      if (set_done)      done <= 1'b1;
      else if (clr_done) done <= 1'b0;
    end
  end
endmodule

// File: rtl/pcopy_tx.sv
module pcopy_tx
  import pcopy_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_base,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_parity,
  output logic              tx_req,
  input  logic              rx_ack,
  input  logic              rx_full,
  output logic              done
);
  localparam logic [DATA_W-1:0] END_WORD = '1;

  cp_state_e         state_q;
  logic              ptr_load, ptr_step, word_load, at_top;
  logic [DATA_W-1:0] word_q;
  logic              par_q, par_in;

  pcopy_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rx_ack     (rx_ack),
    .rx_full    (rx_full),
    .word_is_end(word_q == END_WORD),
    .at_top     (at_top),
    .state      (state_q),
    .ptr_load   (ptr_load),
    .ptr_step   (ptr_step),
    .word_load  (word_load),
    .done       (done)
  );

  pcopy_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ptr_load),
    .step  (ptr_step),
    .base  (src_base),
    .addr  (mem_addr),
    .at_top(at_top)
  );

  pcopy_parity #(.W(DATA_W)) u_par (
    .data    (mem_rdata),
    .even_bit(par_in)
  );

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      par_q  <= 1'b0;
    end else if (word_load) begin
      word_q <= mem_rdata;
      par_q  <= par_in;
    end
  end

  assign mem_rd    = (state_q == ST_FETCH);
  assign tx_req    = (state_q == ST_OFFER);
  assign tx_data   = word_q;
  assign tx_parity = par_q;
endmodule

// File: rtl/pcopy_tx_chk.sv
module pcopy_tx_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] src_base,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_parity,
  input logic              tx_req,
  input logic              rx_ack,
  input logic              rx_full,
  input logic              done,
  input logic              busy
);
  localparam logic [ADDR_W-1:0] TOP  = '1;
  localparam logic [DATA_W-1:0] ENDW = '1;

  a_r1_start_load: assert property (@(negedge clk) disable iff (!rst_n)
    (!busy && start) |=> (mem_rd && mem_addr == $past(src_base)));

  a_r3_even_parity: assert property (@(negedge clk) disable iff (!rst_n)
    tx_req |-> (^{tx_data, tx_parity} == 1'b0));

  a_r4_quiet_fetch: assert property (@(negedge clk) disable iff (!rst_n)
    mem_rd |-> !tx_req);

  a_r5_resend: assert property (@(negedge clk) disable iff (!rst_n)
    (tx_req && !rx_ack && !rx_full) |=> (tx_req && $stable(tx_data) && $stable(tx_parity)));

  a_r6_advance: assert property (@(negedge clk) disable iff (!rst_n)
    (tx_req && rx_ack && !rx_full && tx_data != ENDW && mem_addr != TOP)
    |=> (mem_rd && mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  a_r7_sentinel_end: assert property (@(negedge clk) disable iff (!rst_n)
    (tx_req && rx_ack && tx_data == ENDW) |=> (done && !tx_req));

  a_r8_top_end: assert property (@(negedge clk) disable iff (!rst_n)
    (tx_req && rx_ack && mem_addr == TOP) |=> (done && !tx_req && !mem_rd));

  a_r9_full_halt: assert property (@(negedge clk) disable iff (!rst_n)
    (busy && rx_full) |=> (done && !tx_req && !mem_rd));

  a_r10_done_sticky: assert property (@(negedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r11_start_busy: assert property (@(negedge clk) disable iff (!rst_n)
    (busy && start && !mem_rd && !tx_req && !rx_full) |=> (tx_req && $stable(mem_addr)));
endmodule

bind pcopy_tx pcopy_tx_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .src_base (src_base),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .tx_data  (tx_data),
  .tx_parity(tx_parity),
  .tx_req   (tx_req),
  .rx_ack   (rx_ack),
  .rx_full  (rx_full),
  .done     (done),
  .busy     (state_q != pcopy_pkg::ST_IDLE)
);

// File: tb/pcopy_tx_test.sv
`timescale 1ns/1ps
module pcopy_tx_test;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src_base = '0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] tx_data;
  logic          tx_parity, tx_req, done;
  logic          rx_ack = 1'b0;
  logic          rx_full = 1'b0;

  always #2.5 clk = ~clk;

  pcopy_tx #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_parity(tx_parity), .tx_req(tx_req),
    .rx_ack(rx_ack), .rx_full(rx_full), .done(done)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rx_q[$];
  int  offers = 0;
  bit  nack_mode = 0;
  int  full_limit = 0;
  bit  compare_on = 0;

  // reference model state: 0 idle, 1 reading, 2 capturing, 3 offering
  int            m_st = 0;
  int            m_ptr = 0;
  logic [DW-1:0] m_word = '0;
  bit            m_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // source memory: synchronous read on the falling edge
  always @(negedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  // reference model
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_word = '0; m_done = 0;
    end else begin
      int nst;
      nst = m_st;
      if (m_st == 0) begin
        if (start) begin nst = 1; m_ptr = src_base; m_done = 0; end
      end else if (rx_full) begin
        nst = 0; m_done = 1;
      end else if (m_st == 1) nst = 2;
      else if (m_st == 2) begin m_word = mem[m_ptr]; nst = 3; end
      else if (rx_ack) begin
        if (m_word == 16'hFFFF || m_ptr == DEPTH - 1) begin nst = 0; m_done = 1; end
        else begin m_ptr = m_ptr + 1; nst = 1; end
      end
      m_st = nst;
    end
  end

  // receiver plus per-cycle comparison, on the rising edge
  always @(posedge clk) begin
    if (compare_on) begin
      chk(tx_req == (m_st == 3), "R4 R5 tx_req", tx_req, m_st == 3);
      chk(mem_rd == (m_st == 1), "R1 R2 mem_rd", mem_rd, m_st == 1);
      chk(done == m_done, "R2 R10 done", done, m_done);
      if (m_st == 1) chk(mem_addr == m_ptr[AW-1:0], "R6 R11 mem_addr", mem_addr, m_ptr);
      if (m_st == 3) begin
        chk(tx_data == m_word, "R5 tx_data", tx_data, m_word);
        chk(tx_parity == ^m_word, "R3 tx_parity", tx_parity, ^m_word);
      end
    end
    rx_ack <= 1'b0;
    if (tx_req) begin
      offers++;
      if ((^{tx_data, tx_parity}) == 1'b0 && !(nack_mode && offers % 3 == 1)) begin
        rx_ack <= 1'b1;
        rx_q.push_back(tx_data);
        if (full_limit != 0 && rx_q.size() == full_limit) rx_full <= 1'b1;
      end
    end
  end

  task automatic run_copy(input int base, input bit nack, input int flim, input bit poke, input string tag);
    logic [DW-1:0] exp_q[$];
    int a;
    exp_q = {};
    a = base;
    forever begin
      exp_q.push_back(mem[a]);
      if (flim != 0 && exp_q.size() == flim) break;
      if (mem[a] == 16'hFFFF || a == DEPTH - 1) break;
      a++;
    end
    @(posedge clk);
    rx_q = {}; offers = 0; nack_mode = nack; full_limit = flim;
    rx_full <= 1'b0;
    src_base = base[AW-1:0];
    start = 1'b1;
    @(posedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(posedge clk);
      src_base = '0;
      start = 1'b1;
      @(posedge clk);
      start = 1'b0;
    end
    @(posedge clk);
    while (!done) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(rx_q.size() == exp_q.size(), {tag, " word count"}, rx_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
      chk(rx_q[i] == exp_q[i], {tag, " word"}, rx_q[i], exp_q[i]);
    chk(done == 1'b1, {tag, " done held (R10)"}, done, 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(i * 16'h0421) ^ 16'h5A3C;
      if (mem[i] == 16'hFFFF) mem[i] = 16'h0F0F;
    end
    mem[15] = 16'hFFFF;
    mem[24] = 16'hFFFF;
    mem[33] = 16'hFFFF;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    chk(tx_req == 1'b0, "R12 reset tx_req", tx_req, 0);
    chk(mem_rd == 1'b0, "R12 reset mem_rd", mem_rd, 0);
    chk(done == 1'b0, "R12 reset done", done, 0);
    compare_on = 1;
    run_copy(10, 0, 0, 0, "R7 sentinel copy");
    run_copy(20, 1, 0, 0, "R5 resend copy");
    run_copy(58, 0, 0, 0, "R8 top address copy");
    run_copy(0, 0, 3, 0, "R9 full halt copy");
    run_copy(30, 0, 0, 1, "R11 start while busy");
    run_copy(40, 1, 0, 0, "R6 R1 restart copy");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule